// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor

This block is a small processor that runs one instruction per clock. Each cycle it reads a 16-bit word from an instruction store at the current program counter, decodes it, and updates the accumulator, the zero flag, the register file or the program counter in the same cycle. The program is fixed when the block is built. It comes from a packed parameter vector that the instruction store unpacks into words. The block has no data memory and no external bus.

The instruction set covers an immediate add, an AND with a register, a store of the accumulator into a register, an unconditional jump, a branch taken on zero, and a halt. Every other opcode advances the program counter and changes nothing else. The block has no streaming data path. Its only pins are clock, reset and plain status outputs: the program counter, the accumulator, the zero flag and a halted indicator. A test environment reads these outputs to follow a program as it runs.

Top module: `acc_core`

## Requirements
- R1: While the active-low reset is held, the program counter, accumulator, zero flag, halted output and all registers are zero.
- R2: The opcode is held in bits [15:12] and the operand in bits [11:0]. The codes are 0x1 jump, 0x2 store, 0x3 add-immediate, 0x4 AND-register and 0x5 branch-if-zero, and 0xF is halt.
- R3: Add-immediate adds operand bits [DATA_W-1:0] to the accumulator, wrapping modulo 2^DATA_W. It sets the zero flag exactly when the result is zero.
- R4: Store writes the accumulator into the register selected by the low operand bits. The accumulator and the zero flag do not change.
- R5: AND-register replaces the accumulator with the accumulator ANDed with the selected register. It sets the zero flag exactly when the result is zero.
- R6: Jump loads the program counter with operand bits [PC_W-1:0].
- R7: Branch-if-zero loads the target when the zero flag is set. Otherwise it advances the program counter by one.
- R8: Any opcode not listed in R2 advances the program counter by one and leaves the accumulator and the zero flag unchanged.
- R9: Halt freezes the program counter and asserts the halted output from the next cycle. From then on nothing changes until reset.
- R10: Word i of the program is taken from bits [16*i+15:16*i] of the image parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | PC_W | Current program counter |
| acc_o | output | DATA_W | Accumulator |
| zero_o | output | 1 | Zero flag |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bench builds the core with DATA_W=8, NREG=8 and PC_W=5, which gives a 32-word program space. With an 8-bit data width, small immediates are enough to reach the add wrap-around that sets the zero flag. The 24-word test program fits inside that space and still leaves room for skipped halt words after a taken branch and after a jump. The program also zeroes the accumulator through an AND, checks that a later store leaves the flag alone, and executes an undefined opcode. After the halt, the bench applies reset again to show that the program restarts from word zero.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int OPND_W  = 12;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP  = 4'h0,
    OPC_JMP  = 4'h1,
    OPC_ST   = 4'h2,
    OPC_ADDI = 4'h3,
    OPC_ANDR = 4'h4,
    OPC_BZ   = 4'h5,
    OPC_HALT = 4'hF
  } opcode_e;

  typedef struct packed {
    logic is_jmp;
    logic is_st;
    logic is_addi;
    logic is_andr;
    logic is_bz;
    logic is_halt;
  } dec_t;
endpackage

// File: rtl/acc_rom.sv
module acc_rom
  import acc_pkg::*;
#(
  parameter int PC_W = 6,
  parameter logic [(2**PC_W)*INSTR_W-1:0] IMAGE = '0
) (
  input  logic [PC_W-1:0]    addr,
  output logic [INSTR_W-1:0] word
);
  localparam int DEPTH = 2**PC_W;

  logic [INSTR_W-1:0] words [DEPTH];

  // R10: word i sits at bits [16*i+15 : 16*i] of the image
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = IMAGE[i*INSTR_W +: INSTR_W];
  end

  assign word = words[addr];
endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic [OPND_W-1:0]  operand
);
  logic [OPC_W-1:0] opc;

  assign opc     = instr[INSTR_W-1 -: OPC_W];
  assign operand = instr[OPND_W-1:0];

  always_comb begin
    dec = '0;
    case (opc)
      OPC_JMP:  dec.is_jmp  = 1'b1;
      OPC_ST:   dec.is_st   = 1'b1;
      OPC_ADDI: dec.is_addi = 1'b1;
      OPC_ANDR: dec.is_andr = 1'b1;
      OPC_BZ:   dec.is_bz   = 1'b1;
      OPC_HALT: dec.is_halt = 1'b1;
      default:  dec = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(instr))
      assert_decode_onehot_R2: assert ($onehot0(dec));
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[r] <= '0;
      else if (we && (waddr == IDX_W'(r)))
        mem[r] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  parameter int PC_W   = 6,
  parameter logic [(2**PC_W)*INSTR_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              halted_o
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [PC_W-1:0]    pc_q, pc_nxt;
  logic [DATA_W-1:0]  acc_q, acc_nxt;
  logic               zero_q, halted_q;
  logic [INSTR_W-1:0] instr;
  logic [OPND_W-1:0]  operand;
  dec_t               dec;
  logic [DATA_W-1:0]  imm, rdata;
  logic [PC_W-1:0]    target;
  logic [IDX_W-1:0]   ridx;
  logic               active, take, acc_we, reg_we;

  acc_rom #(.PC_W(PC_W), .IMAGE(IMAGE)) u_rom (
    .addr(pc_q), .word(instr)
  );

  acc_decode u_dec (
    .instr(instr), .dec(dec), .operand(operand)
  );

  assign imm    = operand[DATA_W-1:0];
  assign target = operand[PC_W-1:0];
  assign ridx   = operand[IDX_W-1:0];

  assign active = !halted_q;
  assign take   = active && (dec.is_jmp || (dec.is_bz && zero_q));
  assign acc_we = active && (dec.is_addi || dec.is_andr);
  assign reg_we = active && dec.is_st;

  acc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ridx),
    .wdata(acc_q), .raddr(ridx), .rdata(rdata)
  );

  always_comb begin
    acc_nxt = dec.is_addi ? (acc_q + imm) : (acc_q & rdata);
    if (!active || dec.is_halt) pc_nxt = pc_q;
    else if (take)              pc_nxt = target;
    else                        pc_nxt = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      acc_q    <= '0;
      zero_q   <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (acc_we) begin
        acc_q  <= acc_nxt;
        zero_q <= (acc_nxt == '0);
      end
      if (active && dec.is_halt) halted_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign zero_o   = zero_q;
  assign halted_o = halted_q;

  assert_addi_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dec.is_addi) |=> (acc_q == $past(acc_q + imm)) && (zero_q == (acc_q == '0)));
  assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dec.is_st) |=> $stable(acc_q) && $stable(zero_q));
  assert_and_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dec.is_andr) |=> (zero_q == (acc_q == '0)));
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dec.is_jmp) |=> (pc_q == $past(target)));
  assert_bz_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dec.is_bz && !zero_q) |=> (pc_q == $past(pc_q) + 1'b1));
  assert_other_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (dec == '0)) |=> (pc_q == $past(pc_q) + 1'b1) && $stable(acc_q) && $stable(zero_q));
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q && $stable(pc_q) && $stable(acc_q) && $stable(zero_q));
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  import acc_pkg::*;

  localparam int DATA_W = 8;
  localparam int NREG   = 8;
  localparam int PC_W   = 5;
  localparam int DEPTH  = 2**PC_W;

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] opnd);
    return {op, opnd};
  endfunction

  function automatic logic [DEPTH*16-1:0] build_prog();
    logic [DEPTH*16-1:0] v;
    logic [15:0] w [DEPTH];
    for (int i = 0; i < DEPTH; i++) w[i] = 16'h0000;
    w[0]  = enc(4'h3, 12'h005); // add 5
    w[1]  = enc(4'h2, 12'h003); // store r3
    w[2]  = enc(4'h3, 12'h0FB); // add 0xFB -> wraps to 0
    w[3]  = enc(4'h5, 12'h006); // bz 6 (taken)
    w[4]  = enc(4'h3, 12'h001); // skipped
    w[5]  = enc(4'hF, 12'h000); // skipped
    w[6]  = enc(4'h3, 12'h00E); // add 0x0E
    w[7]  = enc(4'h4, 12'h003); // and r3
    w[8]  = enc(4'h5, 12'h004); // bz 4 (not taken)
    w[9]  = enc(4'h2, 12'h001); // store r1
    w[10] = enc(4'h3, 12'h003); // add 3
    w[11] = enc(4'h4, 12'h003); // and r3
    w[12] = enc(4'h7, 12'hABC); // undefined opcode
    w[13] = enc(4'h1, 12'h00F); // jmp 15
    w[14] = enc(4'hF, 12'h000); // skipped
    w[15] = enc(4'h2, 12'h002); // store r2
    w[16] = enc(4'h3, 12'h0FA); // add 0xFA
    w[17] = enc(4'h4, 12'h001); // and r1
    w[18] = enc(4'h3, 12'h0FF); // add 0xFF
    w[19] = enc(4'h4, 12'h001); // and r1 -> 0
    w[20] = enc(4'h2, 12'h005); // store r5
    w[21] = enc(4'h5, 12'h017); // bz 23 (taken)
    w[22] = enc(4'hF, 12'h000); // skipped
    w[23] = enc(4'hF, 12'h000); // halt
    for (int i = 0; i < DEPTH; i++) v[i*16 +: 16] = w[i];
    return v;
  endfunction

  localparam logic [DEPTH*16-1:0] PROG = build_prog();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] pc_o;
  logic [DATA_W-1:0] acc_o;
  logic zero_o, halted_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acc_core #(.DATA_W(DATA_W), .NREG(NREG), .PC_W(PC_W), .IMAGE(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .acc_o(acc_o),
    .zero_o(zero_o), .halted_o(halted_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to(input int n);
    while (cyc < n) begin
      tick();
      cyc++;
    end
  endtask

  task automatic state(input string req, input int pc, input int acc, input int z, input int h);
    check(req, "pc", 32'(pc_o), 32'(pc));
    check(req, "acc", 32'(acc_o), 32'(acc));
    check(req, "zero", 32'(zero_o), 32'(z));
    check(req, "halted", 32'(halted_o), 32'(h));
  endtask

  task automatic t_reset();
    @(negedge clk);
    state("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic t_add_store();
    run_to(1); state("R3", 1, 8'h05, 0, 0);
    run_to(2); state("R4", 2, 8'h05, 0, 0);
    run_to(3); state("R3", 3, 8'h00, 1, 0); // wrap to zero
  endtask

  task automatic t_branch_taken();
    run_to(4); state("R7", 6, 8'h00, 1, 0);
  endtask

  task automatic t_and_reg();
    run_to(5); state("R3", 7, 8'h0E, 0, 0);
    run_to(6); state("R5", 8, 8'h04, 0, 0); // r3 = 5 from R4 store
  endtask

  task automatic t_branch_not_taken();
    run_to(7); state("R7", 9, 8'h04, 0, 0);
  endtask

  task automatic t_other_opcode();
    run_to(10); state("R5", 12, 8'h05, 0, 0);
    run_to(11); state("R8", 13, 8'h05, 0, 0); // opcode 0x7 per R2 is undefined
  endtask

  task automatic t_jump();
    run_to(12); state("R6", 15, 8'h05, 0, 0);
  endtask

  task automatic t_zero_via_and();
    run_to(14); state("R3", 17, 8'hFF, 0, 0);
    run_to(15); state("R5", 18, 8'h04, 0, 0);
    run_to(17); state("R5", 20, 8'h00, 1, 0);
    run_to(18); state("R4", 21, 8'h00, 1, 0);
  endtask

  task automatic t_halt();
    run_to(19); state("R7", 23, 8'h00, 1, 0);
    run_to(20); state("R9", 23, 8'h00, 1, 1);
    run_to(30); state("R9", 23, 8'h00, 1, 1);
  endtask

  task automatic t_rerun();
    rst_n = 1'b0;
    #5;
    state("R1", 0, 0, 0, 0);
    tick();
    rst_n = 1'b1;
    cyc = 0;
    run_to(1); state("R10", 1, 8'h05, 0, 0);
    run_to(3); state("R10", 3, 8'h00, 1, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_add_store();
    t_branch_taken();
    t_and_reg();
    t_branch_not_taken();
    t_other_opcode();
    t_jump();
    t_zero_via_and();
    t_halt();
    t_rerun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule